// File: doc/BRIEF.md
# Super I/O Configuration Gate

This block is the configuration front end of a multi-function I/O controller. Software reaches it through two byte-wide ports on one bus: an index port (port select 0) and a data port (port select 1). The register space is closed after reset. Two writes of the key byte 0x87 to the index port open it. A write of 0xAA to the index port closes it again.

While the gate is open, an index write chooses a register number. A data write then updates that register. A data read returns it. Register 0x07 holds a logical device number, which steers every per-device access to one of several register banks. In each bank, register 0x30 switches the device on or off. Registers 0x60 to 0xFF are plain byte storage that holds base addresses, interrupt number and type, and any other device settings. The block drives each device's activate bit and its primary 16-bit base address straight to the peripheral logic around it.

Top module: `sio_cfg_gate`

## Requirements
- R1: After reset, the gate is closed, every `dev_active_o` bit is 0, `dev_base_o` is all zero, and once the gate is opened the index, the device number and every per-device register read back as 0x00.
- R2: The gate opens only on two consecutive writes of 0x87 to the index port. Idle cycles between them are allowed. Any other write in between starts the count again: an index write of another value, or any data-port write.
- R3: While the gate is open, an index-port write of 0xAA closes it and leaves the stored index unchanged. After the gate is reopened, the index port reads back the index that was stored before it closed.
- R4: While the gate is closed (including after a single key write), data-port writes and index-port writes other than the key change no register and no output.
- R5: While the gate is closed, reads of either port return 0xFF.
- R6: While the gate is open, an index write other than 0xAA stores the index, which the index port then reads back. A data write goes to the register that the stored index names.
- R7: Register 0x07 stores the full written byte as the device number, which selects the bank for registers 0x30 and 0x60 to 0xFF. If the number is at or above the device count (9), per-device writes are ignored and per-device reads return 0x00.
- R8: A data write to register 0x30 sets the selected device's `dev_active_o` bit to bit 0 of the written byte (0x01 enables, 0x00 disables). The register reads back as {7'b0, that bit}.
- R9: Registers 0x60 to 0xFF are byte storage per device. `dev_base_o[16*d+15 : 16*d]` is {register 0x60, register 0x61} of device d, high byte from 0x60. Registers 0x70/0x71 (interrupt number and type, where 0x02 means edge-triggered active-high) are stored and read back like any other.
- R10: Register numbers other than 0x07, 0x30 and 0x60 to 0xFF read 0x00 and ignore writes.
- R11: `rdata_o` is combinational from the port select and the registered state. In a cycle that both reads and writes, it shows the state before the write, and the write becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| port_i | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte of the port chosen by `port_i` |
| dev_active_o | output | 9 | Activate bit per logical device |
| dev_base_o | output | 144 | 16-bit primary base address per logical device, device 0 in the low bits |

## Verification
A read and a write can fall in the same cycle, because `rdata_o` follows `port_i` while `wr_i` strobes. The worst cases are a data read during the data write to the same register, and an index read during the closing 0xAA write. The bench samples `rdata_o` during every write cycle, before the clock edge. It compares that sample with a model state that has not yet applied the write, then checks the updated value one cycle later. Long random runs interleave key, exit, index and data writes, so these collisions also meet half-finished unlock sequences and out-of-range device numbers.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam logic [7:0] KEY_BYTE    = 8'h87;
    localparam logic [7:0] EXIT_BYTE   = 8'hAA;
    localparam logic [7:0] REG_LDN     = 8'h07;
    localparam logic [7:0] REG_ACT     = 8'h30;
    localparam logic [7:0] REG_BANK_LO = 8'h60;
    localparam logic [7:0] REG_BASE_HI = 8'h60;
    localparam logic [7:0] RD_CLOSED   = 8'hFF;
    localparam int         BANK_SZ     = 256 - int'(REG_BANK_LO);

    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_HALF   = 2'd1,
        GATE_OPEN   = 2'd2
    } gate_e;

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] ldn;
    } gate_regs_t;

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_i,
    input  logic       port_i,
    input  logic [7:0] wdata_i,
    output logic       open_o
);

    typedef struct packed {
        gate_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic key_hit, exit_hit;

    assign key_hit  = wr_i && !port_i && (wdata_i == KEY_BYTE);
    assign exit_hit = wr_i && !port_i && (wdata_i == EXIT_BYTE);

    always_comb begin
        fsm_d = fsm_q;
        if (wr_i) begin
            unique case (fsm_q.st)
                GATE_LOCKED: if (key_hit) fsm_d.st = GATE_HALF;
                GATE_HALF:   fsm_d.st = key_hit ? GATE_OPEN : GATE_LOCKED;
                GATE_OPEN:   if (exit_hit) fsm_d.st = GATE_LOCKED;
                default:     fsm_d.st = GATE_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fsm_q <= '{st: GATE_LOCKED};
        else         fsm_q <= fsm_d;
    end

    assign open_o = (fsm_q.st == GATE_OPEN);

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter int NDEV = 9,
    parameter int DEVW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              act_we_i,
    input  logic              mem_we_i,
    input  logic [DEVW-1:0]   dev_i,
    input  logic [7:0]        off_i,
    input  logic [7:0]        wdata_i,
    output logic              act_rd_o,
    output logic [7:0]        mem_rd_o,
    output logic [NDEV-1:0]   dev_active_o,
    output logic [NDEV*16-1:0] dev_base_o
);

    localparam int HI_OFF = int'(REG_BASE_HI) - int'(REG_BANK_LO);

    typedef struct packed {
        logic              we;
        logic [DEVW-1:0]   dev;
        logic [7:0]        off;
        logic [7:0]        data;
    } mem_req_t;

    logic [NDEV-1:0] act_d, act_q;
    mem_req_t        req_d;
    logic [7:0]      mem_q [NDEV][BANK_SZ];

    always_comb begin
        act_d = act_q;
        if (act_we_i) act_d[dev_i] = wdata_i[0];
        req_d = '{we: mem_we_i, dev: dev_i, off: off_i, data: wdata_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_q <= '0;
            for (int d = 0; d < NDEV; d++)
                for (int o = 0; o < BANK_SZ; o++)
                    mem_q[d][o] <= '0;
        end else begin
            act_q <= act_d;
            if (req_d.we) mem_q[req_d.dev][req_d.off] <= req_d.data;
        end
    end

    assign act_rd_o     = act_q[dev_i];
    assign mem_rd_o     = mem_q[dev_i][off_i];
    assign dev_active_o = act_q;

    for (genvar g = 0; g < NDEV; g++) begin : g_base
        assign dev_base_o[g*16 +: 16] = {mem_q[g][HI_OFF], mem_q[g][HI_OFF+1]};
    end

endmodule

// File: rtl/sio_cfg_gate.sv
module sio_cfg_gate
    import sio_cfg_pkg::*;
#(
    parameter int NDEV = 9
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic               port_i,
    input  logic [7:0]         wdata_i,
    output logic [7:0]         rdata_o,
    output logic [NDEV-1:0]    dev_active_o,
    output logic [NDEV*16-1:0] dev_base_o
);

    localparam int         DEVW   = (NDEV > 1) ? $clog2(NDEV) : 1;
    localparam logic [7:0] NDEV_B = 8'(NDEV);

    gate_regs_t      regs_d, regs_q;
    logic            gate_open;
    logic            idx_wr, dat_wr, dev_ok;
    logic            act_we, mem_we, act_rd;
    logic [DEVW-1:0] dev_sel;
    logic [7:0]      bank_off, mem_rd;

    cfg_key_fsm u_key (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_i),
        .port_i  (port_i),
        .wdata_i (wdata_i),
        .open_o  (gate_open)
    );

    assign idx_wr   = wr_i && !port_i && gate_open && (wdata_i != EXIT_BYTE);
    assign dat_wr   = wr_i && port_i && gate_open;
    assign dev_ok   = (regs_q.ldn < NDEV_B);
    assign dev_sel  = dev_ok ? regs_q.ldn[DEVW-1:0] : '0;
    assign bank_off = (regs_q.idx >= REG_BANK_LO) ? (regs_q.idx - REG_BANK_LO) : 8'h00;
    assign act_we   = dat_wr && dev_ok && (regs_q.idx == REG_ACT);
    assign mem_we   = dat_wr && dev_ok && (regs_q.idx >= REG_BANK_LO);

    always_comb begin
        regs_d = regs_q;
        if (idx_wr) regs_d.idx = wdata_i;
        if (dat_wr && (regs_q.idx == REG_LDN)) regs_d.ldn = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    cfg_dev_bank #(.NDEV(NDEV), .DEVW(DEVW)) u_bank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .act_we_i     (act_we),
        .mem_we_i     (mem_we),
        .dev_i        (dev_sel),
        .off_i        (bank_off),
        .wdata_i      (wdata_i),
        .act_rd_o     (act_rd),
        .mem_rd_o     (mem_rd),
        .dev_active_o (dev_active_o),
        .dev_base_o   (dev_base_o)
    );

    always_comb begin
        if (!gate_open)                   rdata_o = RD_CLOSED;
        else if (!port_i)                 rdata_o = regs_q.idx;
        else if (regs_q.idx == REG_LDN)   rdata_o = regs_q.ldn;
        else if (!dev_ok)                 rdata_o = 8'h00;
        else if (regs_q.idx == REG_ACT)   rdata_o = {7'b0, act_rd};
        else if (regs_q.idx >= REG_BANK_LO) rdata_o = mem_rd;
        else                              rdata_o = 8'h00;
    end

endmodule

// File: rtl/sio_cfg_gate_chk.sv
module sio_cfg_gate_chk #(
    parameter int NDEV = 9
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               wr_i,
    input logic               port_i,
    input logic [7:0]         wdata_i,
    input logic [7:0]         rdata_o,
    input logic [NDEV-1:0]    dev_active_o,
    input logic [NDEV*16-1:0] dev_base_o,
    input logic               open_i,
    input logic [7:0]         idx_i,
    input logic [7:0]         ldn_i
);

    localparam int         DEVW   = (NDEV > 1) ? $clog2(NDEV) : 1;
    localparam logic [7:0] NDEV_B = 8'(NDEV);

    // R5
    closed_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !open_i |-> rdata_o == 8'hFF);

    // R3
    exit_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (open_i && wr_i && !port_i && wdata_i == 8'hAA) |=> (!open_i && $stable(idx_i)));

    // R2
    key_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(open_i) |-> $past(wr_i && !port_i && wdata_i == 8'h87));

    // R4
    closed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!open_i && wr_i) |=> ($stable(dev_active_o) && $stable(dev_base_o)
                               && $stable(idx_i) && $stable(ldn_i)));

    // R8
    act_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (open_i && wr_i && port_i && idx_i == 8'h30 && ldn_i < NDEV_B)
        |=> dev_active_o[$past(ldn_i[DEVW-1:0])] == $past(wdata_i[0]));

    // R7
    ldn_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (open_i && wr_i && port_i && idx_i == 8'h07) |=> ldn_i == $past(wdata_i));

endmodule

bind sio_cfg_gate sio_cfg_gate_chk #(.NDEV(NDEV)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .port_i       (port_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .dev_active_o (dev_active_o),
    .dev_base_o   (dev_base_o),
    .open_i       (gate_open),
    .idx_i        (regs_q.idx),
    .ldn_i        (regs_q.ldn)
);

// File: tb/sim_sio_cfg_gate.sv
`timescale 1ns/1ps
module sim_sio_cfg_gate;

    localparam int ND = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr = 1'b0;
    logic              port = 1'b0;
    logic [7:0]        wdata = 8'h00;
    logic [7:0]        rdata;
    logic [ND-1:0]     act;
    logic [ND*16-1:0]  base;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int         m_st;
    logic [7:0] m_idx, m_ldn;
    logic       m_act [ND];
    logic [7:0] m_mem [ND][160];

    always #4 clk = ~clk;

    sio_cfg_gate #(.NDEV(ND)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .port_i(port),
        .wdata_i(wdata), .rdata_o(rdata), .dev_active_o(act), .dev_base_o(base)
    );

    function automatic logic [7:0] exp_rd(logic p);
        if (m_st != 2)             return 8'hFF;
        if (!p)                    return m_idx;
        if (m_idx == 8'h07)        return m_ldn;
        if (m_ldn >= 8'(ND))       return 8'h00;
        if (m_idx == 8'h30)        return {7'b0, m_act[m_ldn]};
        if (m_idx >= 8'h60)        return m_mem[m_ldn][m_idx - 8'h60];
        return 8'h00;
    endfunction

    function automatic logic [ND-1:0] exp_act();
        logic [ND-1:0] v;
        for (int d = 0; d < ND; d++) v[d] = m_act[d];
        return v;
    endfunction

    function automatic logic [ND*16-1:0] exp_base();
        logic [ND*16-1:0] v;
        for (int d = 0; d < ND; d++) v[d*16 +: 16] = {m_mem[d][0], m_mem[d][1]};
        return v;
    endfunction

    task automatic m_apply(logic p, logic [7:0] d);
        case (m_st)
            0: if (!p && d == 8'h87) m_st = 1;
            1: m_st = (!p && d == 8'h87) ? 2 : 0;
            default: begin
                if (!p) begin
                    if (d == 8'hAA) m_st = 0;
                    else            m_idx = d;
                end else if (m_idx == 8'h07) begin
                    m_ldn = d;
                end else if (m_ldn < 8'(ND)) begin
                    if (m_idx == 8'h30)      m_act[m_ldn] = d[0];
                    else if (m_idx >= 8'h60) m_mem[m_ldn][m_idx - 8'h60] = d;
                end
            end
        endcase
    endtask

    task automatic chk(string req, logic [255:0] got, logic [255:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // one write; rdata sampled inside the write cycle (R11)
    task automatic wr_cycle(logic p, logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; port = p; wdata = d;
        #1;
        chk("R11 read during write", 256'(rdata), 256'(exp_rd(p)));
        @(posedge clk);
        m_apply(p, d);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic check_all(string req);
        port = 1'b0; #1;
        chk({req, " index port"}, 256'(rdata), 256'(exp_rd(1'b0)));
        port = 1'b1; #1;
        chk({req, " data port"}, 256'(rdata), 256'(exp_rd(1'b1)));
        chk({req, " active"}, 256'(act), 256'(exp_act()));
        chk({req, " base"}, 256'(base), 256'(exp_base()));
    endtask

    task automatic reg_wr(logic [7:0] r, logic [7:0] d);
        wr_cycle(1'b0, r);
        wr_cycle(1'b1, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] regs [7];
        m_st = 0; m_idx = 0; m_ldn = 0;
        for (int d = 0; d < ND; d++) begin
            m_act[d] = 1'b0;
            for (int o = 0; o < 160; o++) m_mem[d][o] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R5 closed reads
        check_all("R1 reset");

        // R4 writes while closed
        wr_cycle(1'b1, 8'h55);
        wr_cycle(1'b0, 8'h30);
        wr_cycle(1'b1, 8'h01);
        check_all("R4 closed writes");

        // R2 single key, then broken by data write
        wr_cycle(1'b0, 8'h87);
        check_all("R5 half key");
        wr_cycle(1'b1, 8'h00);
        wr_cycle(1'b0, 8'h87);
        check_all("R2 broken sequence");
        // R2 idle cycles between keys are allowed
        repeat (3) @(negedge clk);
        wr_cycle(1'b0, 8'h87);
        check_all("R2 opened");
        // R1 registers zero once opened
        reg_wr(8'h70, 8'h00);
        check_all("R1 zero regs");

        // R7 device select, R8 activate
        reg_wr(8'h07, 8'h03);
        check_all("R7 ldn");
        reg_wr(8'h30, 8'h01);
        check_all("R8 enable");
        wr_cycle(1'b1, 8'hFE);
        check_all("R8 bit0 only");
        wr_cycle(1'b1, 8'h01);

        // R9 base address and interrupt registers
        reg_wr(8'h60, 8'h12);
        reg_wr(8'h61, 8'h34);
        check_all("R9 base");
        reg_wr(8'h70, 8'h0A);
        reg_wr(8'h71, 8'h02);
        check_all("R9 irq regs");
        reg_wr(8'hFF, 8'hC3);
        check_all("R9 top reg");

        // R7 out-of-range device
        reg_wr(8'h07, 8'h09);
        reg_wr(8'h30, 8'h01);
        check_all("R7 ldn out of range");
        reg_wr(8'h60, 8'h77);
        check_all("R7 ldn out of range mem");

        // R10 unmapped register
        reg_wr(8'h22, 8'hFE);
        check_all("R10 unmapped");

        // R3 exit, closed writes, reopen keeps index
        wr_cycle(1'b0, 8'hAA);
        check_all("R3 exit");
        wr_cycle(1'b1, 8'h99);
        check_all("R4 after exit");
        wr_cycle(1'b0, 8'h87);
        wr_cycle(1'b0, 8'h87);
        check_all("R3 reopen index");
        // R6 index 0x87 while open is just an index
        wr_cycle(1'b0, 8'h87);
        check_all("R6 index 87");

        // random phase
        void'($urandom(32'd20251));
        regs = '{8'h07, 8'h30, 8'h60, 8'h61, 8'h70, 8'h71, 8'h00};
        for (int n = 0; n < 1500; n++) begin
            int r;
            r = int'($urandom % 12);
            if (r == 0 || r == 1) begin
                wr_cycle(1'b0, 8'h87);
            end else if (r == 2) begin
                wr_cycle(1'b0, ($urandom % 3 == 0) ? 8'hAA : 8'h87);
            end else if (r <= 5) begin
                int k;
                k = int'($urandom % 7);
                wr_cycle(1'b0, (k == 6) ? 8'($urandom) : regs[k]);
            end else begin
                wr_cycle(1'b1, (m_idx == 8'h07) ? 8'($urandom % 11) : 8'($urandom));
            end
            check_all("R6 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule